// File: doc/BRIEF.md
# Second-Order Sigma-Delta Bitstream Modulator

This block is a fully digital second-order sigma-delta modulator. On every enabled clock it takes a signed 16-bit sample and emits one registered bit. Over time, the fraction of ones in the stream tracks the sample value. It serves as a stand-in 1-bit converter front end for exercising downstream decimation filters, or as a 1-bit output driver.

Two saturating integrators are cascaded ahead of a sign quantiser. The registered output bit selects a feedback level of plus or minus full scale, and that level is subtracted at both integrator inputs. The feedback magnitude is 2^15, so the ideal ones-density is 0.5 + x/65536. A sample of 0 gives 50 %. A sample of ±20480 (±0.625 of full scale, the nominal working range) gives 81.25 % or 18.75 %. Only the extreme codes drive the stream to all ones or all zeros.

Top module: `sdm2_modulator`

## Requirements
- R1: While rst_ni is low, bit_o is 0 and both integrators are cleared. Deasserting reset in the middle of a run starts the stream again from the cleared state.
- R2: The loop is second order. Each enabled edge computes int1 += x - fb and then int2 += int1_new - fb, and bit_o is set to 1 when int2_new >= 0. Here fb = +32768 if the previous bit_o was 1 and -32768 if it was 0. With x = 0 held from reset, the first eight bits are 1,1,0,1,0,0,1,1.
- R3: A sample of 0 gives exactly 50 % ones: 2048 ones in any 4096-bit window after settling.
- R4: Samples of +20480 and -20480 give 81.25 % and 18.75 % ones (3328 and 768 per 4096), each within ±20.
- R5: For any constant input, the ones-density is 0.5 + x/65536. At x = ±29491 this is 3891 and 205 ones per 4096, each within ±20.
- R6: x = -32768 gives all zeros after settling. x = +32767 gives at least 4076 ones per 4096.
- R7: Both integrators saturate instead of wrapping. After a long run at positive full scale, switching to x = 0 brings the density back to 2048 ±20 per 4096.
- R8: While en_i is low, bit_o and both integrators hold. After en_i returns high, the bit sequence continues exactly as if the paused cycles had not occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Modulator clock; output changes on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Clock enable; low freezes all state |
| sample_i | input | 16 | Signed two's-complement input sample |
| bit_o | output | 1 | Registered 1-bit modulator output |

## Verification
A wrong feedback polarity, a swapped integrator order or a missing reset clear shows up in the first few output bits. From reset, a zero input has one exact eight-bit prefix, so these faults appear within eight cycles. Errors in gain or feedback scale only show as a density offset, which the 4096-bit counting windows detect once settling is over. A wrapping integrator does not show until an extreme input has driven it into its rails. It then shows as a stuck or inverted stream, which the recovery run after full scale exposes within a few thousand cycles.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  localparam int unsigned DEF_IN_W  = 16;
  localparam int unsigned DEF_ACC_W = 24;
  typedef enum logic {Q_NEG = 1'b0, Q_POS = 1'b1} q_level_e;
endpackage

// File: rtl/sdm_integrator.sv
module sdm_integrator #(
  parameter int unsigned ACC_W = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [ACC_W-1:0] add_i,
  input  logic signed [ACC_W-1:0] sub_i,
  output logic signed [ACC_W-1:0] acc_o,
  output logic signed [ACC_W-1:0] acc_next_o
);
  localparam int unsigned EXT_W = ACC_W + 2;
  localparam logic signed [EXT_W-1:0] MAX_E = {3'b000, {(ACC_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] MIN_E = {3'b111, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_q;
  logic signed [EXT_W-1:0] sum;

  always_comb begin
    sum = EXT_W'(acc_q) + EXT_W'(add_i) - EXT_W'(sub_i);
    if (sum > MAX_E)      acc_next_o = MAX_E[ACC_W-1:0];
    else if (sum < MIN_E) acc_next_o = MIN_E[ACC_W-1:0];
    else                  acc_next_o = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= acc_next_o;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/sdm_quantizer.sv
module sdm_quantizer
  import sdm_pkg::*;
#(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned ACC_W = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [ACC_W-1:0] level_i,
  output logic                    bit_o,
  output logic signed [ACC_W-1:0] fb_o
);
  localparam logic signed [ACC_W-1:0] FB_POS =
    {{(ACC_W-IN_W){1'b0}}, 1'b1, {(IN_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] FB_NEG = -FB_POS;

  q_level_e q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= Q_NEG;
    else if (en_i) q_q <= level_i[ACC_W-1] ? Q_NEG : Q_POS;
  end

  assign bit_o = (q_q == Q_POS);
  assign fb_o  = (q_q == Q_POS) ? FB_POS : FB_NEG;
endmodule

// File: rtl/sdm2_modulator.sv
module sdm2_modulator
  import sdm_pkg::*;
#(
  parameter int unsigned IN_W  = DEF_IN_W,
  parameter int unsigned ACC_W = DEF_ACC_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic signed [IN_W-1:0] sample_i,
  output logic                   bit_o
);
  localparam int unsigned NUM_STAGES = 2;

  logic signed [ACC_W-1:0] x_ext;
  logic signed [ACC_W-1:0] fb;
  logic signed [ACC_W-1:0] int1_q, int2_q;
  logic signed [ACC_W-1:0] stage_in   [NUM_STAGES];
  logic signed [ACC_W-1:0] stage_q    [NUM_STAGES];
  logic signed [ACC_W-1:0] stage_next [NUM_STAGES];

  assign x_ext       = ACC_W'(sample_i);
  assign stage_in[0] = x_ext;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    if (s > 0) begin : g_chain
      assign stage_in[s] = stage_next[s-1];
    end
    sdm_integrator #(.ACC_W(ACC_W)) u_int (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en_i),
      .add_i      (stage_in[s]),
      .sub_i      (fb),
      .acc_o      (stage_q[s]),
      .acc_next_o (stage_next[s])
    );
  end

  assign int1_q = stage_q[0];
  assign int2_q = stage_q[1];

  sdm_quantizer #(.IN_W(IN_W), .ACC_W(ACC_W)) u_quant (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .level_i (stage_next[NUM_STAGES-1]),
    .bit_o   (bit_o),
    .fb_o    (fb)
  );
endmodule

// File: rtl/sdm2_modulator_chk.sv
module sdm2_modulator_chk #(
  parameter int unsigned ACC_W = 24
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    en_i,
  input logic                    bit_o,
  input logic signed [ACC_W-1:0] int1_i,
  input logic signed [ACC_W-1:0] int2_i
);
  localparam logic signed [ACC_W-1:0] QUART = {2'b01, {(ACC_W-2){1'b0}}};

  AST_RST_LOW: assert property (@(posedge clk_i)
    !rst_ni |-> (!bit_o && int1_i == '0 && int2_i == '0)); // R1

  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(bit_o) && $stable(int1_i) && $stable(int2_i))); // R8

  AST_NO_WRAP_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int2_i >= QUART) |=> !int2_i[ACC_W-1]); // R7

  AST_NO_WRAP_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int2_i < -QUART) |=> int2_i[ACC_W-1]); // R7
endmodule

bind sdm2_modulator sdm2_modulator_chk #(.ACC_W(ACC_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .bit_o  (bit_o),
  .int1_i (int1_q),
  .int2_i (int2_q)
);

// File: tb/sdm2_modulator_tb.sv
`timescale 1ns/1ps
module sdm2_modulator_tb;
  localparam int WIN = 4096;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic signed [15:0] sample_i = '0;
  logic bit_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    int    lo;
    int    hi;
    string tag;
  } exp_t;
  exp_t exp_q[$];
  event win_start, win_done;

  sdm2_modulator u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .sample_i (sample_i),
    .bit_o    (bit_o)
  );

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cycles <= cycles + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    en_i   = 1'b1;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // driver: push expected window, start monitor
  task automatic density_case(input logic signed [15:0] x, input int lo, input int hi,
                              input string tag, input int settle, input bit rst_first);
    exp_t e;
    if (rst_first) do_reset();
    sample_i = x;
    repeat (settle) @(negedge clk_i);
    e.lo = lo; e.hi = hi; e.tag = tag;
    exp_q.push_back(e);
    ->win_start;
    @(win_done);
  endtask

  // monitor: count ones, pop and compare
  initial begin
    forever begin
      int cnt;
      exp_t e;
      @(win_start);
      cnt = 0;
      repeat (WIN) begin
        @(negedge clk_i);
        cnt += int'(bit_o);
      end
      e = exp_q.pop_front();
      check(cnt >= e.lo && cnt <= e.hi, e.tag, cnt, (e.lo + e.hi) / 2);
      ->win_done;
    end
  end

  initial begin
    if (cycles < 0) $display("unreachable");
    wait (cycles >= 190000);
    errors++;
    $display("FAIL watchdog: actual %0d expected <190000 cycles", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ref_bits [64];
    bit got_bits [64];
    bit seq_ok;
    bit hold_ok;
    bit last;
    bit exp_seq [8] = '{1, 1, 0, 1, 0, 0, 1, 1};

    // R1: reset state
    #1;
    check(bit_o == 1'b0, "R1 reset low", int'(bit_o), 0);

    // R2: exact zero-input prefix from reset
    do_reset();
    sample_i = 16'sd0;
    seq_ok = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i);
      if (bit_o != exp_seq[k]) seq_ok = 1'b0;
      check(bit_o == exp_seq[k], "R2 zero-input bit", int'(bit_o), int'(exp_seq[k]));
    end

    // R1: async reset mid-run forces the output low
    sample_i = 16'sd32767;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(bit_o == 1'b0, "R1 mid-run reset", int'(bit_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    sample_i = 16'sd0;
    @(negedge clk_i);
    check(bit_o == 1'b1, "R1 restart first bit", int'(bit_o), 1);

    // R8: reference run
    do_reset();
    sample_i = 16'sd9830;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk_i);
      ref_bits[k] = bit_o;
    end
    // R8: paused run
    do_reset();
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      got_bits[k] = bit_o;
    end
    en_i = 1'b0;
    last = bit_o;
    hold_ok = 1'b1;
    repeat (30) begin
      @(negedge clk_i);
      if (bit_o != last) hold_ok = 1'b0;
    end
    check(hold_ok, "R8 hold while disabled", int'(bit_o), int'(last));
    en_i = 1'b1;
    for (int k = 20; k < 64; k++) begin
      @(negedge clk_i);
      got_bits[k] = bit_o;
    end
    seq_ok = 1'b1;
    for (int k = 0; k < 64; k++) if (got_bits[k] != ref_bits[k]) seq_ok = 1'b0;
    check(seq_ok, "R8 resumed sequence", int'(seq_ok), 1);

    // density windows
    density_case(16'sd0,      2048, 2048, "R3 zero 50%",      512, 1'b1);
    density_case(16'sd20480,  3308, 3348, "R4 +0.625",        512, 1'b1);
    density_case(-16'sd20480,  748,  788, "R4 -0.625",        512, 1'b1);
    density_case(16'sd29491,  3871, 3911, "R5 +0.9",          512, 1'b1);
    density_case(-16'sd29491,  185,  225, "R5 -0.9",          512, 1'b1);
    density_case(16'sd8192,   2540, 2580, "R5 +0.25",         512, 1'b1);
    density_case(-16'sd32768,    0,    0, "R6 neg full",      512, 1'b1);
    density_case(16'sd32767,  4076, 4096, "R6 pos full",      512, 1'b1);
    // R7: saturate at full scale, then recover without reset
    density_case(16'sd32767,  4076, 4096, "R7 saturated run", 40000, 1'b1);
    density_case(16'sd0,      2028, 2068, "R7 recovery",      2000, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule